// File: doc/BRIEF.md
# Predicate-Count Saturating Decrement Unit

This block takes a 64-bit scalar and lowers it by the number of active lanes in a vector predicate, treating the scalar as a signed integer and clamping the result instead of letting it wrap. A 2-bit size code sets the lane width: 8, 16, 32 or 64 bits. Each lane is governed by one predicate bit, the lowest bit of that lane's group of predicate bits. The number of lanes is the vector length divided by the lane width.

A width bit chooses between two modes. In 32-bit mode, only the low word of the scalar is used. The result is clamped to the 32-bit signed range and then sign-extended to 64 bits. In 64-bit mode, the result is clamped to the 64-bit signed range. A flag reports each time clamping takes place.

The vector length is a compile-time parameter. An optional output register gives the unit one cycle of latency, with a valid bit that travels alongside the data. Without that register, the valid bit passes straight through.

Top module: `pred_sat_dec`

## Requirements
- R1: The size code sets the lane width in bits to 8 << code (0 → 8, 1 → 16, 2 → 32, 3 → 64). Each lane's governing bit is predicate bit e·(width/8). The decrement equals the number of governing bits that are 1, and all other predicate bits have no effect.
- R2: All VL/width lanes are counted. With an all-ones predicate and VL = 256, the decrement is 32, 16, 8 or 4 for size codes 0 to 3.
- R3: With wide = 0, bits 63:32 of the operand have no effect on the output.
- R4: With wide = 0, a difference below −2^31 gives 0xFFFFFFFF80000000 with satFlag = 1. A difference of exactly −2^31 gives the same value with satFlag = 0.
- R5: With wide = 1, a difference below −2^63 gives 0x8000000000000000 with satFlag = 1. A difference of exactly −2^63 gives the same value with satFlag = 0.
- R6: With wide = 0, the 32-bit result is sign-extended, so outScalar[63:32] copies outScalar[31].
- R7: When no clamping occurs, outScalar equals the operand minus the count and satFlag = 0. A zero count returns the operand unchanged.
- R8: With REGISTERED = 1, the result and outValid appear on the clock edge after the one that samples inValid = 1. outValid falls after an edge that samples inValid = 0.
- R9: While rstN is low, outValid, outScalar and satFlag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operands are valid this cycle |
| opScalar | input | 64 | Signed scalar operand |
| predMask | input | VEC_BITS/8 | Predicate register |
| sizeCode | input | 2 | Lane width code |
| wide | input | 1 | 1: 64-bit mode, 0: 32-bit mode |
| outValid | output | 1 | Result is valid |
| outScalar | output | 64 | Decremented, clamped and extended scalar |
| satFlag | output | 1 | Clamping took place |

## Verification
A faulty lane-stride decode appears at the outputs on the first registered result as a wrong decrement. The error only shows when the predicate sets bits off the lane boundaries, so vectors with alternating bit patterns are used. A clamp comparator that is off by one only shows at the exact minimum value, which is why each mode is driven at the minimum, one past it, and above it. A stuck valid or result register shows one cycle after any operation, or straight after reset.

// File: rtl/psd_pkg.sv
package psd_pkg;
  typedef struct packed {
    logic [3:0] sizeOneHot;
    logic       wide;
    logic       load;
  } psd_ctrl_t;

  localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;
  localparam logic [63:0] MAX64 = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MIN32X = 64'hFFFF_FFFF_8000_0000;
  localparam logic [63:0] MAX32X = 64'h0000_0000_7FFF_FFFF;
endpackage

// File: rtl/psd_ctrl.sv
module psd_ctrl
  import psd_pkg::*;
(
  input  logic       inValid,
  input  logic [1:0] sizeCode,
  input  logic       wide,
  output psd_ctrl_t  ctrl
);
  always_comb begin
    ctrl.sizeOneHot = 4'b0001 << sizeCode;
    ctrl.wide       = wide;
    ctrl.load       = inValid;
  end
endmodule

// File: rtl/psd_datapath.sv
module psd_datapath
  import psd_pkg::*;
#(
  parameter int VEC_BITS   = 256,
  parameter bit REGISTERED = 1'b1,
  localparam int PL = VEC_BITS / 8,
  localparam int CW = $clog2(PL) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  psd_ctrl_t     ctrl,
  input  logic [63:0]   opScalar,
  input  logic [PL-1:0] predMask,
  output logic          outValid,
  output logic [63:0]   outScalar,
  output logic          satFlag
);
  logic [3:0][CW-1:0] laneCnt;
  logic [CW-1:0]      activeCnt;

  for (genvar g = 0; g < 4; g++) begin : g_stride
    localparam int STRIDE = 1 << g;
    localparam int LANES  = PL / STRIDE;
    always_comb begin
      laneCnt[g] = '0;
      for (int e = 0; e < LANES; e++) begin
        laneCnt[g] = laneCnt[g] + CW'(predMask[e*STRIDE]);
      end
    end
  end

  always_comb begin
    activeCnt = '0;
    for (int g = 0; g < 4; g++) begin
      if (ctrl.sizeOneHot[g]) activeCnt = laneCnt[g];
    end
  end

  logic signed [64:0] opExt;
  logic signed [64:0] diff;
  logic [63:0]        resComb;
  logic               satComb;
  logic               narrowOver;

  always_comb begin
    opExt = ctrl.wide ? {opScalar[63], opScalar} : {{33{opScalar[31]}}, opScalar[31:0]};
    diff  = opExt - $signed({{(65-CW){1'b0}}, activeCnt});
    narrowOver = !((&diff[64:31]) || !(|diff[64:31]));
    satComb = 1'b0;
    if (ctrl.wide) begin
      if (diff[64] != diff[63]) begin
        satComb = 1'b1;
        resComb = diff[64] ? MIN64 : MAX64;
      end else begin
        resComb = diff[63:0];
      end
    end else begin
      if (narrowOver) begin
        satComb = 1'b1;
        resComb = diff[64] ? MIN32X : MAX32X;
      end else begin
        resComb = {{32{diff[31]}}, diff[31:0]};
      end
    end
  end

  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outValid  <= 1'b0;
        outScalar <= '0;
        satFlag   <= 1'b0;
      end else begin
        outValid <= ctrl.load;
        if (ctrl.load) begin
          outScalar <= resComb;
          satFlag   <= satComb;
        end
      end
    end

    p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rstN)
      ctrl.load |=> outValid);
    p_valid_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
      !ctrl.load |=> !outValid);
  end else begin : g_comb
    always_comb begin
      outValid  = ctrl.load;
      outScalar = resComb;
      satFlag   = satComb;
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |-> (int'(activeCnt) <= (PL >> $clog2(ctrl.sizeOneHot))));
  p_sext_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && !ctrl.wide) |-> (resComb[63:32] == {32{resComb[31]}}));
  p_sat_min_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.wide && satComb) |-> (resComb == MIN64));
  p_sat_min_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && !ctrl.wide && satComb) |-> (resComb == MIN32X));
  p_no_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.wide && !satComb) |-> ($signed(resComb) <= $signed(opScalar)));
endmodule

// File: rtl/pred_sat_dec.sv
module pred_sat_dec
  import psd_pkg::*;
#(
  parameter int VEC_BITS   = 256,
  parameter bit REGISTERED = 1'b1,
  localparam int PL = VEC_BITS / 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [63:0]   opScalar,
  input  logic [PL-1:0] predMask,
  input  logic [1:0]    sizeCode,
  input  logic          wide,
  output logic          outValid,
  output logic [63:0]   outScalar,
  output logic          satFlag
);
  psd_ctrl_t ctrl;

  psd_ctrl u_ctrl (
    .inValid (inValid),
    .sizeCode(sizeCode),
    .wide    (wide),
    .ctrl    (ctrl)
  );

  psd_datapath #(
    .VEC_BITS  (VEC_BITS),
    .REGISTERED(REGISTERED)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .opScalar (opScalar),
    .predMask (predMask),
    .outValid (outValid),
    .outScalar(outScalar),
    .satFlag  (satFlag)
  );
endmodule

// File: tb/tb_pred_sat_dec.sv
module tb_pred_sat_dec;
  localparam int CLK_PERIOD = 10;
  localparam int VL = 256;
  localparam int PL = VL / 8;

  typedef struct packed {
    logic [63:0] op;
    logic [31:0] pr;
    logic [1:0]  sz;
    logic        w;
    logic [63:0] res;
    logic        sat;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{64'd100, 32'hFFFF_FFFF, 2'd0, 1'b1, 64'd68, 1'b0},
    '{64'd100, 32'hFFFF_FFFF, 2'd1, 1'b1, 64'd84, 1'b0},
    '{64'd100, 32'hFFFF_FFFF, 2'd2, 1'b1, 64'd92, 1'b0},
    '{64'd100, 32'hFFFF_FFFF, 2'd3, 1'b1, 64'd96, 1'b0},
    '{64'd100, 32'hAAAA_AAAA, 2'd1, 1'b1, 64'd100, 1'b0},
    '{64'd100, 32'hAAAA_AAAA, 2'd0, 1'b1, 64'd84, 1'b0},
    '{64'h8000_0000_0000_0000, 32'h0000_0001, 2'd3, 1'b1, 64'h8000_0000_0000_0000, 1'b1},
    '{64'h8000_0000_0000_0003, 32'h0000_000F, 2'd0, 1'b1, 64'h8000_0000_0000_0000, 1'b1},
    '{64'h8000_0000_0000_0004, 32'h0000_000F, 2'd0, 1'b1, 64'h8000_0000_0000_0000, 1'b0},
    '{64'hDEAD_BEEF_8000_0002, 32'h0000_0007, 2'd0, 1'b0, 64'hFFFF_FFFF_8000_0000, 1'b1},
    '{64'h1234_5678_8000_0003, 32'h0000_0007, 2'd0, 1'b0, 64'hFFFF_FFFF_8000_0000, 1'b0},
    '{64'hFFFF_FFFF_0000_0005, 32'h0000_0101, 2'd3, 1'b0, 64'd3, 1'b0},
    '{64'h0000_0000_0000_0001, 32'h0000_0003, 2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
    '{64'h7FFF_FFFF_FFFF_FFFF, 32'h0000_0000, 2'd2, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0},
    '{64'hAAAA_AAAA_7FFF_FFFF, 32'h1111_1111, 2'd2, 1'b0, 64'h0000_0000_7FFF_FFF7, 1'b0},
    '{64'd5, 32'hEEEE_EEEE, 2'd2, 1'b1, 64'd5, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [63:0]   opScalar = '0;
  logic [PL-1:0] predMask = '0;
  logic [1:0]    sizeCode = '0;
  logic          wide = 1'b0;
  logic          outValid;
  logic [63:0]   outScalar;
  logic          satFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pred_sat_dec #(.VEC_BITS(VL), .REGISTERED(1'b1)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opScalar(opScalar),
    .predMask(predMask), .sizeCode(sizeCode), .wide(wide),
    .outValid(outValid), .outScalar(outScalar), .satFlag(satFlag)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [63:0] op, input logic [31:0] pr,
                                input logic [1:0] sz, input logic w,
                                output logic [63:0] res, output logic sat);
    int step = 1 << sz;
    int cnt = 0;
    logic signed [64:0] a;
    logic signed [64:0] lo;
    for (int i = 0; i < PL; i += step) cnt += int'(pr[i]);
    a  = w ? $signed({op[63], op}) : $signed({{33{op[31]}}, op[31:0]});
    a  = a - 65'(cnt);
    lo = w ? -(65'sd1 <<< 63) : -(65'sd1 <<< 31);
    sat = (a < lo);
    if (sat) a = lo;
    res = a[63:0];
  endfunction

  task automatic apply(input logic [63:0] op, input logic [31:0] pr,
                       input logic [1:0] sz, input logic w);
    opScalar = op; predMask = pr; sizeCode = sz; wide = w; inValid = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 outValid", 64'(outValid), 64'd0);
    check("R9 outScalar", outScalar, 64'd0);
    check("R9 satFlag", 64'(satFlag), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Table walk: R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].pr, VECS[i].sz, VECS[i].w);
      check($sformatf("R1/R2/R3/R4/R5/R6/R7 vec%0d result", i), outScalar, VECS[i].res);
      check($sformatf("R4/R5/R7 vec%0d sat", i), 64'(satFlag), 64'(VECS[i].sat));
      check($sformatf("R8 vec%0d valid", i), 64'(outValid), 64'd1);
    end

    // R8: valid drops one edge after inValid falls
    inValid = 1'b0;
    @(negedge clk);
    check("R8 valid low", 64'(outValid), 64'd0);

    // R3: upper word has no effect in 32-bit mode
    apply(64'h0000_0000_0000_0010, 32'h0000_0003, 2'd0, 1'b0);
    check("R3 baseline", outScalar, 64'd14);
    apply(64'hFFFF_0000_0000_0010, 32'h0000_0003, 2'd0, 1'b0);
    check("R3 upper ignored", outScalar, 64'd14);

    // Random against model with bias near minimum values: R1 R4 R5 R7
    for (int i = 0; i < 300; i++) begin
      logic [63:0] op;
      logic [31:0] pr;
      logic [1:0]  sz;
      logic        w;
      logic [63:0] eRes;
      logic        eSat;
      op = {$urandom, $urandom};
      pr = $urandom;
      sz = 2'($urandom_range(0, 3));
      w  = 1'($urandom_range(0, 1));
      case (i % 3)
        0: op = 64'h8000_0000_0000_0000 | 64'($urandom_range(0, 40));
        1: op[31:0] = 32'h8000_0000 | 32'($urandom_range(0, 40));
        default: ;
      endcase
      model(op, pr, sz, w, eRes, eSat);
      apply(op, pr, sz, w);
      check("R1/R7 random result", outScalar, eRes);
      check("R4/R5 random sat", 64'(satFlag), 64'(eSat));
    end
    inValid = 1'b0;
    @(negedge clk);

    // R9: asynchronous reset clears outputs
    rstN = 1'b0;
    #1;
    check("R9 reset valid", 64'(outValid), 64'd0);
    check("R9 reset scalar", outScalar, 64'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule